// File: doc/BRIEF.md
# Paged Flash Erase Sequencer

This block turns one erase request, a byte offset and a byte length, into the sequence of erase commands that a serial paged flash needs. It sends them over a byte-wide handshake to an SPI master that shifts the bits. Before it sends anything, it divides the offset and the length by the configured page size. Either remainder, or a zero page size, ends the request with an alignment error, and chip select never asserts.

The range is then covered one step at a time. When the current page index sits on an eight-page boundary and at least eight pages remain, the step erases a whole block. Otherwise it erases one page. After each command the sequencer waits a set number of cycles, then reads the device status. It repeats that wait and read until the ready flag comes back, or until the time since the command ends exceeds a limit. The page size and the page-address shift come in as configuration inputs, so the same block serves geometries that are and are not powers of two. A single-cycle done pulse carries the result code.

Top module: `erase_seq`

## Requirements
- R1: A request whose offset or length is not a whole multiple of `cfg_page_size`, or that comes with a page size of zero, ends with `err_code` 1. No chip select frame is issued.
- R2: The step's opcode is 0x50 (block erase) when the current page index has bits 2:0 equal to zero and at least 8 pages remain. Otherwise it is 0x81 (page erase).
- R3: Each erase command is a frame of exactly four bytes, in this order: the opcode, bits 23:16 of the flash address, bits 15:8 of the flash address, and 0x00. The flash address is the page index shifted left by `cfg_page_shift`.
- R4: After a block erase the page index advances by 8 and the remaining count drops by 8. After a page erase both move by one. The sequence ends when no pages remain.
- R5: After every command the block reads status with a two-byte frame: 0xD7, then a dummy 0x00. Only bit 7 of the byte returned with the dummy is examined, and 1 means ready. Erasing moves on only after a ready status.
- R6: Chip select stays low for at least `POLL_GAP` cycles before each status frame.
- R7: `spi_cs` is high for the whole of one frame and low between frames. `xfer_req` is never high while `spi_cs` is low.
- R8: If a status read returns not-ready and at least `TIMEOUT_CYC` cycles have passed since the command ended, the request ends with `err_code` 2. No further command is sent.
- R9: `done` is a single-cycle pulse per request. `err_code` is 0 on success. `busy` is high from acceptance until `done`.
- R10: A length of zero ends with `err_code` 0 and no frames.
- R11: `req_valid` while `busy` is high is ignored.
- R12: A byte on `xfer_tx` stays stable with `xfer_req` high until `xfer_ack` accepts it. `xfer_rx` is taken in the cycle of `xfer_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start an erase when idle |
| req_offset | input | ADDR_W | Byte offset of the range |
| req_len | input | ADDR_W | Byte length of the range |
| cfg_page_size | input | PS_W | Page size in bytes |
| cfg_page_shift | input | SH_W | Left shift from page index to flash address |
| busy | output | 1 | Request in progress |
| spi_cs | output | 1 | Chip select, active high, framing one command |
| xfer_req | output | 1 | Byte exchange requested |
| xfer_tx | output | 8 | Byte to send |
| xfer_ack | input | 1 | Exchange complete, one cycle |
| xfer_rx | input | 8 | Byte received in the exchange |
| done | output | 1 | End of request, one cycle |
| err_code | output | 2 | 0 ok, 1 misaligned, 2 timeout; valid with done |

## Verification
The bench builds the block with `POLL_GAP` at 8 and `TIMEOUT_CYC` at 300. That setting leaves `ADDR_W` and the sizes at their defaults. With these values the bench can reach status polling with several busy replies and a stuck device that hits the timeout, all within a few hundred cycles. Geometries of 264/9, 256/8 and 1056/11 exercise the non-power-of-two division, the block/page choice at boundaries, and high address bytes.

// File: rtl/erase_pkg.sv
package erase_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DIV, S_CMD, S_GAP, S_POLL, S_STEP, S_END
  } seq_st_t;

  localparam logic [7:0] OP_BLK_ERASE = 8'h50;
  localparam logic [7:0] OP_PG_ERASE  = 8'h81;
  localparam logic [7:0] OP_STATUS    = 8'hD7;

  localparam logic [1:0] ERR_OK    = 2'd0;
  localparam logic [1:0] ERR_ALIGN = 2'd1;
  localparam logic [1:0] ERR_TMO   = 2'd2;

  localparam int BLK_PAGES = 8;
endpackage

// File: rtl/erase_div.sv
module erase_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         fin
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    acc_q, acc_d;
  logic [W-1:0]  q_q, q_d, d_q, d_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d, fin_q, fin_d;
  logic [W:0]    shifted;

  assign shifted = {acc_q[W-1:0], q_q[W-1]};

  always_comb begin
    acc_d = acc_q;
    q_d   = q_q;
    d_d   = d_q;
    cnt_d = cnt_q;
    run_d = run_q;
    fin_d = fin_q;
    if (start) begin
      acc_d = '0;
      q_d   = dividend;
      d_d   = divisor;
      cnt_d = CW'(W);
      run_d = 1'b1;
      fin_d = 1'b0;
    end else if (run_q) begin
      if (shifted >= {1'b0, d_q}) begin
        acc_d = shifted - {1'b0, d_q};
        q_d   = {q_q[W-2:0], 1'b1};
      end else begin
        acc_d = shifted;
        q_d   = {q_q[W-2:0], 1'b0};
      end
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_d = 1'b0;
        fin_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      q_q   <= '0;
      d_q   <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      q_q   <= q_d;
      d_q   <= d_d;
      cnt_q <= cnt_d;
      run_q <= run_d;
      fin_q <= fin_d;
    end
  end

  assign quo = q_q;
  assign rem = acc_q[W-1:0];
  assign fin = fin_q;
endmodule

// File: rtl/erase_seq.sv
module erase_seq
  import erase_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PS_W        = 16,
  parameter int SH_W        = 4,
  parameter int POLL_GAP    = 20000,
  parameter int TIMEOUT_CYC = 400000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [ADDR_W-1:0] req_len,
  input  logic [PS_W-1:0]   cfg_page_size,
  input  logic [SH_W-1:0]   cfg_page_shift,
  output logic              busy,
  output logic              spi_cs,
  output logic              xfer_req,
  output logic [7:0]        xfer_tx,
  input  logic              xfer_ack,
  input  logic [7:0]        xfer_rx,
  output logic              done,
  output logic [1:0]        err_code
);
  localparam int GAP_W = $clog2(POLL_GAP + 1);
  localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [GAP_W-1:0]  GAP_LAST = GAP_W'(POLL_GAP - 1);
  localparam logic [TMO_W-1:0]  TMO_LIM  = TMO_W'(TIMEOUT_CYC);
  localparam logic [TMO_W-1:0]  TMO_MAX  = '1;
  localparam logic [ADDR_W-1:0] BLK_N    = ADDR_W'(BLK_PAGES);

  seq_st_t           st_q, st_d;
  logic [ADDR_W-1:0] pg_idx_q, pg_idx_d, pg_rem_q, pg_rem_d;
  logic [1:0]        bidx_q, bidx_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic [TMO_W-1:0]  tmo_q, tmo_d;
  logic [1:0]        err_q, err_d;
  logic [SH_W-1:0]   sh_q, sh_d;
  logic              psz_q, psz_d;

  logic                   div_start;
  logic [1:0][ADDR_W-1:0] dvd, quo, rem;
  logic [1:0]             fin;

  assign div_start = (st_q == S_IDLE) && req_valid;
  assign dvd[0] = req_offset;
  assign dvd[1] = req_len;

  for (genvar g = 0; g < 2; g++) begin : g_div
    erase_div #(.W(ADDR_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (div_start),
      .dividend (dvd[g]),
      .divisor  (ADDR_W'(cfg_page_size)),
      .quo      (quo[g]),
      .rem      (rem[g]),
      .fin      (fin[g])
    );
  end

  logic              is_blk;
  logic [ADDR_W-1:0] faddr, step;
  logic [7:0]        op_byte;

  assign is_blk  = (pg_idx_q[2:0] == 3'd0) && (pg_rem_q >= BLK_N);
  assign step    = is_blk ? BLK_N : ADDR_W'(1);
  assign faddr   = pg_idx_q << sh_q;
  assign op_byte = is_blk ? OP_BLK_ERASE : OP_PG_ERASE;

  always_comb begin
    xfer_tx = 8'h00;
    if (st_q == S_CMD) begin
      case (bidx_q)
        2'd0:    xfer_tx = op_byte;
        2'd1:    xfer_tx = faddr[23:16];
        2'd2:    xfer_tx = faddr[15:8];
        default: xfer_tx = 8'h00;
      endcase
    end else if (st_q == S_POLL && bidx_q == 2'd0) begin
      xfer_tx = OP_STATUS;
    end
  end

  always_comb begin
    st_d     = st_q;
    pg_idx_d = pg_idx_q;
    pg_rem_d = pg_rem_q;
    bidx_d   = bidx_q;
    gap_d    = gap_q;
    tmo_d    = tmo_q;
    err_d    = err_q;
    sh_d     = sh_q;
    psz_d    = psz_q;
    case (st_q)
      S_IDLE: if (req_valid) begin
        st_d  = S_DIV;
        err_d = ERR_OK;
        sh_d  = cfg_page_shift;
        psz_d = (cfg_page_size == '0);
      end
      S_DIV: if (fin[0]) begin
        if (psz_q || rem[0] != '0 || rem[1] != '0) begin
          err_d = ERR_ALIGN;
          st_d  = S_END;
        end else if (quo[1] == '0) begin
          st_d = S_END;
        end else begin
          pg_idx_d = quo[0];
          pg_rem_d = quo[1];
          bidx_d   = 2'd0;
          st_d     = S_CMD;
        end
      end
      S_CMD: if (xfer_ack) begin
        if (bidx_q == 2'd3) begin
          st_d  = S_GAP;
          gap_d = '0;
          tmo_d = '0;
        end else begin
          bidx_d = bidx_q + 2'd1;
        end
      end
      S_GAP: begin
        if (tmo_q != TMO_MAX) tmo_d = tmo_q + 1'b1;
        if (gap_q == GAP_LAST) begin
          st_d   = S_POLL;
          bidx_d = 2'd0;
        end else begin
          gap_d = gap_q + 1'b1;
        end
      end
      S_POLL: begin
        if (tmo_q != TMO_MAX) tmo_d = tmo_q + 1'b1;
        if (xfer_ack) begin
          if (bidx_q == 2'd0) begin
            bidx_d = 2'd1;
          end else if (xfer_rx[7]) begin
            st_d = S_STEP;
          end else if (tmo_q >= TMO_LIM) begin
            err_d = ERR_TMO;
            st_d  = S_END;
          end else begin
            st_d  = S_GAP;
            gap_d = '0;
          end
        end
      end
      S_STEP: begin
        pg_idx_d = pg_idx_q + step;
        pg_rem_d = pg_rem_q - step;
        bidx_d   = 2'd0;
        st_d     = (pg_rem_q == step) ? S_END : S_CMD;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      pg_idx_q <= '0;
      pg_rem_q <= '0;
      bidx_q   <= '0;
      gap_q    <= '0;
      tmo_q    <= '0;
      err_q    <= ERR_OK;
      sh_q     <= '0;
      psz_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      pg_idx_q <= pg_idx_d;
      pg_rem_q <= pg_rem_d;
      bidx_q   <= bidx_d;
      gap_q    <= gap_d;
      tmo_q    <= tmo_d;
      err_q    <= err_d;
      sh_q     <= sh_d;
      psz_q    <= psz_d;
    end
  end

  assign spi_cs   = (st_q == S_CMD) || (st_q == S_POLL);
  assign xfer_req = spi_cs;
  assign busy     = (st_q != S_IDLE);
  assign done     = (st_q == S_END);
  assign err_code = err_q;
endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       spi_cs,
  input logic       xfer_req,
  input logic [7:0] xfer_tx,
  input logic       xfer_ack,
  input logic       done,
  input logic [1:0] err_code
);
  a_r7_req_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> spi_cs);

  a_r7_cs_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_cs);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err_code != 2'd3));

  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r12_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx)));

  a_r2_frame_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs) |-> (xfer_tx == 8'h50 || xfer_tx == 8'h81 || xfer_tx == 8'hD7));
endmodule

bind erase_seq erase_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .spi_cs   (spi_cs),
  .xfer_req (xfer_req),
  .xfer_tx  (xfer_tx),
  .xfer_ack (xfer_ack),
  .done     (done),
  .err_code (err_code)
);

// File: tb/sim_erase_seq.sv
`timescale 1ns/1ps
module sim_erase_seq;
  localparam int GAP = 8;
  localparam int TMO = 300;

  logic clk, rst_n, req_valid, busy, spi_cs, xfer_req, xfer_ack, done;
  logic [31:0] req_offset, req_len;
  logic [15:0] cfg_page_size;
  logic [3:0]  cfg_page_shift;
  logic [7:0]  xfer_tx, xfer_rx;
  logic [1:0]  err_code;

  erase_seq #(.POLL_GAP(GAP), .TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
    .req_len(req_len), .cfg_page_size(cfg_page_size), .cfg_page_shift(cfg_page_shift),
    .busy(busy), .spi_cs(spi_cs), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
    .xfer_ack(xfer_ack), .xfer_rx(xfer_rx), .done(done), .err_code(err_code));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk, n_fail;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // device model state
  logic [31:0] cmds [64];
  logic [31:0] exp_cmds [64];
  int n_cmd, n_poll, n_frames, busy_polls, poll_in_cmd, min_gap, low_cnt, bad_frames;
  int lat, flen, done_cnt;
  bit stuck, cs_prev;
  logic [7:0] fr [8];
  logic [1:0] last_err;

  initial begin
    xfer_ack = 1'b0; xfer_rx = 8'h00; cs_prev = 1'b0; lat = 0; flen = 0;
    low_cnt = 0; done_cnt = 0; last_err = 2'd0;
  end

  always @(negedge clk) begin
    if (done) begin done_cnt++; last_err = err_code; end
    if (spi_cs && !cs_prev) begin
      flen = 0;
      if (xfer_tx == 8'hD7 && low_cnt < min_gap) min_gap = low_cnt;
    end
    if (!spi_cs && cs_prev) begin
      n_frames++;
      if (fr[0] == 8'hD7) begin
        n_poll++; poll_in_cmd++;
        if (flen != 2 || fr[1] != 8'h00) bad_frames++;
      end else begin
        if (flen != 4 || fr[3] != 8'h00) bad_frames++;
        if (n_cmd < 64) cmds[n_cmd] = {fr[0], fr[1], fr[2], fr[3]};
        n_cmd++; poll_in_cmd = 0;
      end
    end
    low_cnt = spi_cs ? 0 : low_cnt + 1;
    cs_prev = spi_cs;
    if (xfer_ack) begin
      xfer_ack = 1'b0;
    end else if (xfer_req) begin
      lat++;
      if (lat == 2) begin
        lat = 0;
        if (flen < 8) fr[flen] = xfer_tx;
        if (flen == 1 && fr[0] == 8'hD7)
          xfer_rx = (!stuck && poll_in_cmd >= busy_polls) ? 8'hBC : 8'h7F;
        else
          xfer_rx = 8'hFF;
        flen++;
        xfer_ack = 1'b1;
      end
    end
  end

  function automatic int build_exp(input int off_pg, input int n_pg, input int sh);
    int idx = off_pg, rem = n_pg, k = 0;
    while (rem > 0 && k < 64) begin
      bit blk = (idx % 8 == 0) && (rem >= 8);
      logic [31:0] a = idx << sh;
      exp_cmds[k] = {blk ? 8'h50 : 8'h81, a[23:16], a[15:8], 8'h00};
      k++;
      idx += blk ? 8 : 1;
      rem -= blk ? 8 : 1;
    end
    return k;
  endfunction

  task automatic run_erase(input logic [31:0] off, input logic [31:0] len, input int ps,
                           input int sh, input int bpolls, input bit stk, input bit poke);
    int d0;
    n_cmd = 0; n_poll = 0; n_frames = 0; bad_frames = 0; min_gap = 1 << 30;
    busy_polls = bpolls; stuck = stk; poll_in_cmd = 0;
    cfg_page_size = 16'(ps); cfg_page_shift = 4'(sh);
    d0 = done_cnt;
    @(negedge clk);
    req_offset = off; req_len = len; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      req_offset = 0; req_len = 32'(8 * ps); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(done_cnt == d0 + 1, "R9 one done pulse", done_cnt - d0, 1);
  endtask

  task automatic t_reset;
    chk(!busy && !spi_cs && !xfer_req && !done, "R9 reset idle", {busy, spi_cs, xfer_req, done}, 0);
  endtask

  task automatic t_align;
    run_erase(32'd100, 32'(264 * 4), 264, 9, 0, 0, 0);
    chk(last_err == 2'd1, "R1 offset misaligned code", last_err, 1);
    chk(n_frames == 0, "R1 no frames on bad offset", n_frames, 0);
    run_erase(32'(264 * 2), 32'd500, 264, 9, 0, 0, 0);
    chk(last_err == 2'd1, "R1 length misaligned code", last_err, 1);
    chk(n_frames == 0, "R1 no frames on bad length", n_frames, 0);
    run_erase(32'd0, 32'd0, 0, 9, 0, 0, 0);
    chk(last_err == 2'd1, "R1 zero page size", last_err, 1);
  endtask

  task automatic t_zero;
    run_erase(32'(264 * 3), 32'd0, 264, 9, 0, 0, 0);
    chk(last_err == 2'd0, "R10 zero length ok", last_err, 0);
    chk(n_frames == 0, "R10 zero length no frames", n_frames, 0);
  endtask

  task automatic cmp_cmds(input int n_exp, input string tag);
    chk(n_cmd == n_exp, tag, n_cmd, n_exp);
    for (int i = 0; i < n_exp && i < n_cmd; i++)
      chk(cmds[i] == exp_cmds[i], tag, cmds[i], exp_cmds[i]);
  endtask

  task automatic t_mixed;
    int n;
    run_erase(32'(264 * 6), 32'(264 * 20), 264, 9, 1, 0, 0);
    n = build_exp(6, 20, 9);
    cmp_cmds(n, "R2 R3 R4 mixed range commands");
    chk(last_err == 2'd0, "R9 mixed ok code", last_err, 0);
    chk(n_poll == 2 * n, "R5 one busy then ready per command", n_poll, 2 * n);
    chk(min_gap >= GAP, "R6 gap before poll", min_gap, GAP);
    chk(bad_frames == 0, "R7 R12 frame lengths and trailing zero", bad_frames, 0);
  endtask

  task automatic t_pow2;
    run_erase(32'd0, 32'(256 * 8), 256, 8, 0, 0, 0);
    chk(n_cmd == 1 && cmds[0] == 32'h5000_0000, "R2 single block erase", cmds[0], 32'h5000_0000);
    chk(n_poll == 1, "R5 ready on first poll", n_poll, 1);
  endtask

  task automatic t_seven;
    int n;
    run_erase(32'd0, 32'(256 * 7), 256, 8, 0, 0, 0);
    n = build_exp(0, 7, 8);
    cmp_cmds(n, "R2 R4 seven pages use page erase");
  endtask

  task automatic t_big;
    run_erase(32'(1056 * 1000), 32'd1056, 1056, 11, 2, 0, 0);
    chk(n_cmd == 1 && cmds[0] == 32'h811F_4000, "R3 high address bytes", cmds[0], 32'h811F_4000);
    chk(n_poll == 3, "R5 two busy replies", n_poll, 3);
  endtask

  task automatic t_tmo;
    run_erase(32'd0, 32'(264 * 16), 264, 9, 0, 1, 0);
    chk(last_err == 2'd2, "R8 timeout code", last_err, 2);
    chk(n_cmd == 1, "R8 no command after timeout", n_cmd, 1);
    chk(n_poll >= 2, "R8 polled repeatedly", n_poll, 2);
  endtask

  task automatic t_busy_req;
    int n;
    run_erase(32'(264 * 3), 32'(264 * 12), 264, 9, 1, 0, 1);
    n = build_exp(3, 12, 9);
    cmp_cmds(n, "R11 request while busy ignored");
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_offset = '0; req_len = '0;
    cfg_page_size = 16'd264; cfg_page_shift = 4'd9;
    busy_polls = 0; stuck = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_align();
    t_zero();
    t_mixed();
    t_pow2();
    t_seven();
    t_big();
    t_tmo();
    t_busy_req();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule